// File: doc/BRIEF.md
# 8-bit ALU with Flag Unit

This block is the arithmetic and logic datapath of a small 8-bit processor core, together with the five-flag register that goes with it. The result byte is produced combinationally from two operand bytes, a 4-bit operation code and the flags currently held. When the core asserts `exec_i`, the new flags are captured on the next rising clock edge. The flags are sign (S), zero (Z), auxiliary carry (AC, the carry out of bit 3), parity (P) and carry (CY).

Every addition and subtraction runs through a chain of 4-bit adders. The carry between the two nibbles is the auxiliary carry, and the carry out of the top nibble is the carry. Subtraction adds the complement of the second operand. The block also packs the flags into a status byte for saving on a stack, and loads them back from such a byte through `restore_i`. A 3-bit condition code is evaluated against the held flags for conditional branches.

`result_o` and `cond_true_o` follow their inputs in the same cycle. `status_o` reflects the flag register, so it changes one clock edge after `exec_i` or `restore_i`.

Top module: `alu8_flag_unit`

## Requirements
- R1: Op 0 (add) gives result = a + b and op 1 (add with carry) gives result = a + b + CY, both modulo 256. The new CY is set when the true sum exceeds 255.
- R2: For every add and subtract form, the new AC is the carry out of the low-nibble add, a[3:0] + y[3:0] + cin > 15. Here y is b for adds and ~b for subtracts, and cin is the carry-in of that operation.
- R3: Op 2 (subtract) gives a − b with cin = 1. Op 3 (subtract with borrow) gives a − b − CY with cin = ~CY. For both, the new CY is set when a borrow occurs, meaning the true difference is negative.
- R4: After any defined operation, S equals result bit 7, Z is set when the result is 0x00, and P is set when the result has an even number of one bits.
- R5: Op 7 (AND), op 8 (XOR) and op 9 (OR) give the bitwise result of a and b, and they clear both CY and AC.
- R6: Op 5 (increment) gives a + 1 and op 6 (decrement) gives a − 1. Operand b is ignored. CY keeps its old value. AC is set for increment when a[3:0] = 0xF, and for decrement when a[3:0] ≠ 0.
- R7: Op 4 (compare) updates the flags exactly as subtract does, but it holds `acc_we_o` low. For the other defined ops, `acc_we_o` equals `exec_i`.
- R8: `status_o` packs the flags as follows: bit 0 = CY, bit 1 = 1, bit 2 = P, bit 4 = AC, bit 6 = Z, bit 7 = S. Bits 3 and 5 read 0.
- R9: With `restore_i` high, the next edge loads CY, P, AC, Z and S from bits 0, 2, 4, 6 and 7 of `status_i`. Restore takes priority over `exec_i`.
- R10: `cond_true_o` evaluates `cond_i` against the held flags: 0 = Z clear, 1 = Z set, 2 = CY clear, 3 = CY set, 4 = P clear (odd), 5 = P set (even), 6 = S clear, 7 = S set.
- R11: Reset clears all five flags, so `status_o` = 0x02. The flags hold whenever neither `exec_i` nor `restore_i` is high.
- R12: Op codes 10 to 15 are undefined. They output `result_o` = a, leave the flags unchanged and hold `acc_we_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| op_i | input | 4 | Operation code (see R1 to R12) |
| a_i | input | 8 | First operand (accumulator) |
| b_i | input | 8 | Second operand |
| exec_i | input | 1 | Commit the operation's flags at the next edge |
| restore_i | input | 1 | Load the flags from `status_i` at the next edge |
| status_i | input | 8 | Packed status byte to restore |
| cond_i | input | 3 | Condition code to evaluate |
| result_o | output | 8 | Result byte |
| acc_we_o | output | 1 | Result is meant to be written to the accumulator |
| status_o | output | 8 | Packed status byte of the held flags |
| cond_true_o | output | 1 | Selected condition holds |

## Verification
The assertions assume that `op_i`, `exec_i` and `restore_i` are stable, known values around each rising edge, and that `status_i` is meaningful only while `restore_i` is high. The stimulus drives all inputs shortly after the falling edge and never changes them near the rising edge.

The stimulus draws op codes across the full 4-bit range, so the undefined codes are covered too. It asserts `restore_i` on roughly one step in eight, sometimes together with `exec_i`, so that the priority rule is exercised. Directed steps set up the nibble-carry and wrap cases at 0x0F, 0xFF and 0x00.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_CMP = 4'd4,
    OP_INR = 4'd5,
    OP_DCR = 4'd6,
    OP_AND = 4'd7,
    OP_XOR = 4'd8,
    OP_OR  = 4'd9
  } alu_op_e;

  typedef enum logic [2:0] {
    CC_NZ = 3'd0,
    CC_Z  = 3'd1,
    CC_NC = 3'd2,
    CC_C  = 3'd3,
    CC_PO = 3'd4,
    CC_PE = 3'd5,
    CC_P  = 3'd6,
    CC_M  = 3'd7
  } cond_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  localparam int STAT_W   = 8;
  localparam int POS_CY   = 0;
  localparam int POS_ONE  = 1;
  localparam int POS_P    = 2;
  localparam int POS_AC   = 4;
  localparam int POS_Z    = 6;
  localparam int POS_S    = 7;
endpackage

// File: rtl/alu8_nib_add.sv
module alu8_nib_add #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  assign {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  flags_t            cur,
  output logic [DATA_W-1:0] res,
  output flags_t            nxt,
  output logic              known,
  output logic              writes_acc
);
  localparam int NIBS = DATA_W / NIB_W;

  logic [DATA_W-1:0] opnd_y;
  logic              cin;
  logic              borrow_mode;
  logic [DATA_W-1:0] sum;
  logic [NIBS:0]     carry;

  always_comb begin
    opnd_y      = b;
    cin         = 1'b0;
    borrow_mode = 1'b0;
    case (op)
      OP_ADD: begin opnd_y = b; cin = 1'b0; end
      OP_ADC: begin opnd_y = b; cin = cur.cy; end
      OP_SUB, OP_CMP: begin opnd_y = ~b; cin = 1'b1; borrow_mode = 1'b1; end
      OP_SBB: begin opnd_y = ~b; cin = ~cur.cy; borrow_mode = 1'b1; end
      OP_INR: begin opnd_y = DATA_W'(1); cin = 1'b0; end
      OP_DCR: begin opnd_y = ~DATA_W'(1); cin = 1'b1; end
      default: begin opnd_y = b; cin = 1'b0; end
    endcase
  end

  assign carry[0] = cin;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    alu8_nib_add #(.W(NIB_W)) u_nib (
      .x   (a[g*NIB_W +: NIB_W]),
      .y   (opnd_y[g*NIB_W +: NIB_W]),
      .cin (carry[g]),
      .sum (sum[g*NIB_W +: NIB_W]),
      .cout(carry[g+1])
    );
  end

  always_comb begin
    res        = a;
    nxt        = cur;
    known      = 1'b1;
    writes_acc = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        res    = sum;
        nxt.ac = carry[1];
        nxt.cy = borrow_mode ? ~carry[NIBS] : carry[NIBS];
        if (op == OP_CMP) writes_acc = 1'b0;
      end
      OP_INR, OP_DCR: begin
        res    = sum;
        nxt.ac = carry[1];
        nxt.cy = cur.cy;
      end
      OP_AND: begin res = a & b; nxt.ac = 1'b0; nxt.cy = 1'b0; end
      OP_XOR: begin res = a ^ b; nxt.ac = 1'b0; nxt.cy = 1'b0; end
      OP_OR:  begin res = a | b; nxt.ac = 1'b0; nxt.cy = 1'b0; end
      default: begin
        res        = a;
        known      = 1'b0;
        writes_acc = 1'b0;
      end
    endcase
    if (known) begin
      nxt.s = res[DATA_W-1];
      nxt.z = (res == '0);
      nxt.p = ~^res;
    end
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  flags_t            nxt,
  input  logic              restore,
  input  logic [STAT_W-1:0] status_in,
  output flags_t            flags,
  output logic [STAT_W-1:0] status_out
);
  flags_t loaded;

  always_comb begin
    loaded.cy = status_in[POS_CY];
    loaded.p  = status_in[POS_P];
    loaded.ac = status_in[POS_AC];
    loaded.z  = status_in[POS_Z];
    loaded.s  = status_in[POS_S];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flags <= '0;
    else if (restore) flags <= loaded;
    else if (upd)     flags <= nxt;
  end

  always_comb begin
    status_out          = '0;
    status_out[POS_CY]  = flags.cy;
    status_out[POS_ONE] = 1'b1;
    status_out[POS_P]   = flags.p;
    status_out[POS_AC]  = flags.ac;
    status_out[POS_Z]   = flags.z;
    status_out[POS_S]   = flags.s;
  end

  assert_restore_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (status_out == (($past(status_in) & 8'hD5) | 8'h02)));

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && !upd) |=> $stable(flags));
endmodule

// File: rtl/alu8_cond.sv
module alu8_cond
  import alu8_pkg::*;
(
  input  cond_e  cc,
  input  flags_t flags,
  output logic   hit
);
  always_comb begin
    case (cc)
      CC_NZ:   hit = ~flags.z;
      CC_Z:    hit =  flags.z;
      CC_NC:   hit = ~flags.cy;
      CC_C:    hit =  flags.cy;
      CC_PO:   hit = ~flags.p;
      CC_PE:   hit =  flags.p;
      CC_P:    hit = ~flags.s;
      default: hit =  flags.s;
    endcase
  end
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              exec_i,
  input  logic              restore_i,
  input  logic [7:0]        status_i,
  input  logic [2:0]        cond_i,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_we_o,
  output logic [7:0]        status_o,
  output logic              cond_true_o
);
  flags_t flags_q;
  flags_t flags_nxt;
  logic   op_known;
  logic   op_writes;

  alu8_core #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_core (
    .op        (alu_op_e'(op_i)),
    .a         (a_i),
    .b         (b_i),
    .cur       (flags_q),
    .res       (result_o),
    .nxt       (flags_nxt),
    .known     (op_known),
    .writes_acc(op_writes)
  );

  alu8_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (exec_i && op_known),
    .nxt       (flags_nxt),
    .restore   (restore_i),
    .status_in (status_i),
    .flags     (flags_q),
    .status_out(status_o)
  );

  alu8_cond u_cond (
    .cc   (cond_e'(cond_i)),
    .flags(flags_q),
    .hit  (cond_true_o)
  );

  assign acc_we_o = exec_i && op_writes;

  assert_keep_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !restore_i && (op_i == OP_INR || op_i == OP_DCR))
      |=> (status_o[0] == $past(status_o[0])));

  assert_logic_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !restore_i && (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR))
      |=> (!status_o[0] && !status_o[4]));

  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |-> !acc_we_o);

  assert_cond_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == CC_Z) |-> (cond_true_o == status_o[6]));

  assert_undef_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_i && op_i >= 4'd10) |=> $stable(status_o));
endmodule

// File: tb/alu8_flag_unit_bench.sv
module alu8_flag_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_i;
  logic [7:0] a_i, b_i, status_i;
  logic       exec_i, restore_i;
  logic [2:0] cond_i;
  logic [7:0] result_o, status_o;
  logic       acc_we_o, cond_true_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flag_unit u_alu8_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .exec_i(exec_i), .restore_i(restore_i), .status_i(status_i),
    .cond_i(cond_i), .result_o(result_o), .acc_we_o(acc_we_o),
    .status_o(status_o), .cond_true_o(cond_true_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model(input int op, input logic [7:0] a, input logic [7:0] b,
                                input logic [7:0] st, output logic [7:0] r,
                                output logic [7:0] nst, output bit we, output bit valid);
    int t, cin;
    bit cy, ac, ncy, nac;
    cy = st[0]; ncy = cy; nac = 1'b0; valid = 1'b1; we = 1'b1; r = a;
    case (op)
      0, 1: begin
        cin = (op == 1) ? int'(cy) : 0;
        t = int'(a) + int'(b) + cin;
        r = 8'(t); ncy = (t > 255);
        nac = ((int'(a) & 15) + (int'(b) & 15) + cin) > 15;
      end
      2, 3, 4: begin
        cin = (op == 3) ? int'(cy) : 0;
        t = int'(a) - int'(b) - cin;
        r = 8'(t); ncy = (t < 0);
        nac = ((int'(a) & 15) + ((~int'(b)) & 15) + (1 - cin)) > 15;
        if (op == 4) we = 1'b0;
      end
      5: begin r = a + 8'd1; nac = (a[3:0] == 4'hF); end
      6: begin r = a - 8'd1; nac = (a[3:0] != 4'h0); end
      7: begin r = a & b; ncy = 0; nac = 0; end
      8: begin r = a ^ b; ncy = 0; nac = 0; end
      9: begin r = a | b; ncy = 0; nac = 0; end
      default: begin valid = 1'b0; we = 1'b0; r = a; end
    endcase
    if (valid) nst = {r[7], (r == 8'h00), 1'b0, nac, 1'b0, ~^r, 1'b1, ncy};
    else       nst = st;
  endfunction

  function automatic bit cond_model(input int cc, input logic [7:0] st);
    case (cc)
      0: return !st[6];
      1: return st[6];
      2: return !st[0];
      3: return st[0];
      4: return !st[2];
      5: return st[2];
      6: return !st[7];
      default: return st[7];
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0, 1:    return "R1";
      2, 3:    return "R3";
      4:       return "R7";
      5, 6:    return "R6";
      7, 8, 9: return "R5";
      default: return "R12";
    endcase
  endfunction

  task automatic step(input int op, input logic [7:0] a, input logic [7:0] b,
                      input bit ex, input bit rs, input logic [7:0] sti, input int cc);
    logic [7:0] r, nst;
    bit we, valid;
    op_i = 4'(op); a_i = a; b_i = b; exec_i = ex; restore_i = rs;
    status_i = sti; cond_i = 3'(cc);
    model(op, a, b, exp_st, r, nst, we, valid);
    #1;
    check({req_of(op), " result"}, result_o, r);
    check("R7 acc_we", acc_we_o, int'(ex && we));
    check("R10 cond", cond_true_o, int'(cond_model(cc, exp_st)));
    @(posedge clk);
    if (rs)             exp_st = (sti & 8'hD5) | 8'h02;
    else if (ex && valid) exp_st = nst;
    @(negedge clk);
    if (rs) check("R9 restore", status_o, exp_st);
    else    check({req_of(op), " R2 R4 R8 flags"}, status_o, exp_st);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    rst_n = 1'b0; op_i = 0; a_i = 0; b_i = 0; exec_i = 0; restore_i = 0;
    status_i = 0; cond_i = 0;
    exp_st = 8'h02;
    repeat (3) @(negedge clk);
    check("R11 reset status", status_o, 8'h02);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4: 0xFF + 0x01 wraps to zero with CY, AC, Z, P
    step(0, 8'hFF, 8'h01, 1, 0, 0, 1);
    check("R1 wrap status", status_o, 8'h57);
    // R1: add with carry uses CY=1
    step(1, 8'h0E, 8'h01, 1, 0, 0, 3);
    // R6: increment 0xFF keeps CY=0
    step(2, 8'h05, 8'h05, 1, 0, 0, 0);
    step(5, 8'hFF, 8'h33, 1, 0, 0, 2);
    check("R6 inc keeps CY", status_o[0], 0);
    // R3: subtract with borrow, borrow out
    step(2, 8'h00, 8'h01, 1, 0, 0, 0);
    step(3, 8'h10, 8'h0F, 1, 0, 0, 3);
    // R6: decrement 0x00 with CY=0
    step(6, 8'h00, 8'h00, 1, 0, 0, 5);
    // R9: restore all ones, and restore beats exec
    step(7, 8'h00, 8'h00, 1, 1, 8'hFF, 0);
    check("R8 R9 packed ones", status_o, 8'hD7);
    step(0, 8'h01, 8'h01, 1, 1, 8'h00, 1);
    check("R9 restore zero", status_o, 8'h02);
    // R12: undefined code with exec leaves flags
    step(12, 8'h5A, 8'hA5, 1, 0, 0, 6);
    // R11: no exec, flags hold
    step(0, 8'hFF, 8'hFF, 0, 0, 0, 7);

    for (int i = 0; i < 2500; i++) begin
      int op, cc;
      bit ex, rs;
      op = int'($urandom_range(15, 0));
      cc = int'($urandom_range(7, 0));
      ex = ($urandom_range(3, 0) != 0);
      rs = ($urandom_range(7, 0) == 0);
      step(op, 8'($urandom), 8'($urandom), ex, rs, 8'($urandom), cc);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule